// File: doc/BRIEF.md
# Ownership-Gated Store Commit Buffer

This block sits between the retire stage of a core and its private L1 data cache. Retired stores enter a small queue in program order and leave it one at a time, oldest first. A store is written into the cache only while its line is held with write permission (exclusive or modified). Until that write happens, the store is not visible to any other agent. When the oldest store finds its line without write permission, the block sends one request for ownership toward the next coherence level. It then waits for a single grant reply, which installs the line as exclusive. The next level gathers any per-core acknowledgements itself.

When the oldest store is held up and no request is in flight, the second-oldest store may have its line fetched early with the same request channel. Snoop invalidations never cancel, stall or alter a buffered store. The block only watches them to see whether an early-fetched line was taken away before its store used it. A small saturating counter records such losses. Once the counter reaches two, look-ahead fetching stops.

Line states on every state port are encoded as 0 = invalid, 1 = shared, 2 = exclusive, 3 = modified. A line address is address bits [AW-1:6].

Top module: `sb_commit`

## Requirements
- R1: A push is accepted only while `st_full_o` is low. `st_full_o` is high exactly when 8 stores are held, and a push presented while it is high is dropped and never reaches the cache.
- R2: Stores reach the cache strictly in the order they were accepted. Only the oldest store drives `l1_addr_o`, `l1_wr_data_o` and `l1_wr_mask_o`, and a store becomes visible only in a cycle with `l1_wr_o` high.
- R3: `l1_wr_o` rises only when a store is held, `l1_rdy_i` is high and `l1_state_i` is 2 or 3. The written line's new state on `l1_wr_state_o` is 3, so exclusive becomes modified and modified stays modified.
- R4: When the oldest store's line is in state 0 or 1 and no request is in flight, `own_req_o` rises on the next cycle carrying that store's line. It is held with a stable line until a single one-cycle `own_gnt_i`, after which the store commits once the line shows state 2.
- R5: At most one ownership request is outstanding, and `own_req_o` is low in the cycle after a grant.
- R6: An invalidation changes neither the order, the contents nor the count of buffered stores. Every store held during invalidations still commits with its own data.
- R7: When the oldest store needs no request, no request is in flight and prefetching is enabled, a request is issued for the second-oldest store's line if that line is in state 0 or 1 and differs from the oldest store's line. A request for the oldest store always wins over a prefetch.
- R8: An invalidation of the most recently prefetched line that arrives after its grant and before a store commits to it increments a 2-bit saturating loss counter. A commit to that line in the same cycle as the invalidation counts as a use, not a loss. No prefetch is issued while the counter is 2 or more.
- R9: A store whose prefetched line was lost issues a new request for that line once it is the oldest store, and commits after the new grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| st_vld_i | input | 1 | Retired store push strobe |
| st_addr_i | input | AW | Store byte address |
| st_data_i | input | DW | Store data |
| st_mask_i | input | DW/8 | Store byte enables |
| st_full_o | output | 1 | Buffer holds DEPTH stores |
| l1_addr_o | output | AW | Address of the oldest store (lookup and write) |
| l1_state_i | input | 2 | Cache state of the line at `l1_addr_o` |
| l1_rdy_i | input | 1 | Cache can accept a write this cycle |
| l1_wr_o | output | 1 | Commit the oldest store this cycle |
| l1_wr_data_o | output | DW | Data of the oldest store |
| l1_wr_mask_o | output | DW/8 | Byte enables of the oldest store |
| l1_wr_state_o | output | 2 | New state for the written line |
| pf_line_o | output | AW-6 | Line of the second-oldest store (lookup) |
| pf_state_i | input | 2 | Cache state of the line at `pf_line_o` |
| own_req_o | output | 1 | Ownership request in flight |
| own_line_o | output | AW-6 | Line being requested |
| own_gnt_i | input | 1 | Single grant completing the request |
| inv_vld_i | input | 1 | Incoming invalidation |
| inv_line_i | input | AW-6 | Line being invalidated |

## Verification
Two functions can land in the same clock edge: the commit of a store into a line that was fetched early for it, and an invalidation of that same line. The bench holds the cache write-ready low so the early fetch completes while an older store waits. It then releases ready and places the invalidation exactly in the cycle the second store is written. The outcome is judged through the ports afterwards. Two deliberate losses must each still see a prefetch request, and only a third attempt must see none. A collision wrongly counted as a loss would switch prefetching off one round early.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_e;

  function automatic logic has_wr_perm(input logic [1:0] st);
    return (st == ST_E) || (st == ST_M);
  endfunction

endpackage

// File: rtl/sb_fifo.sv
module sb_fifo #(
  parameter int DEPTH = 8,   // power of two
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int LW    = 26,
  localparam int MW   = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [DW-1:0] push_data_i,
  input  logic [MW-1:0] push_mask_i,
  input  logic          pop_i,
  output logic          push_acc_o,
  output logic          full_o,
  output logic          head_vld_o,
  output logic [AW-1:0] head_addr_o,
  output logic [DW-1:0] head_data_o,
  output logic [MW-1:0] head_mask_o,
  output logic          nxt_vld_o,
  output logic [LW-1:0] nxt_line_o
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [MW-1:0] mask_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q, rd_nx;
  logic [CW-1:0] cnt_q;
  logic          pop_acc;

  assign full_o     = (cnt_q == CW'(DEPTH));
  assign push_acc_o = push_i && !full_o;
  assign head_vld_o = (cnt_q != '0);
  assign nxt_vld_o  = (cnt_q > CW'(1));
  assign pop_acc    = pop_i && head_vld_o;
  assign rd_nx      = rd_q + PW'(1);

  assign head_addr_o = addr_q[rd_q];
  assign head_data_o = data_q[rd_q];
  assign head_mask_o = mask_q[rd_q];
  assign nxt_line_o  = addr_q[rd_nx][AW-1:AW-LW];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i) begin
      if (push_acc_o && (wr_q == PW'(i))) begin
        addr_q[i] <= push_addr_i;
        data_q[i] <= push_data_i;
        mask_q[i] <= push_mask_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_acc_o) wr_q <= wr_q + PW'(1);
      if (pop_acc)    rd_q <= rd_nx;
      case ({push_acc_o, pop_acc})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R1
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));

  // R1
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i |=> full_o && $stable(wr_q));

  // R2
  pop_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_acc && !push_acc_o |=> cnt_q == $past(cnt_q) - CW'(1));

endmodule

// File: rtl/sb_own_ctrl.sv
module sb_own_ctrl #(
  parameter int LW     = 26,
  parameter int CNT_W  = 2,
  parameter int PF_OFF = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          head_vld_i,
  input  logic [LW-1:0] head_line_i,
  input  logic          head_own_i,
  input  logic          nxt_vld_i,
  input  logic [LW-1:0] nxt_line_i,
  input  logic          nxt_own_i,
  input  logic          commit_i,
  input  logic          own_gnt_i,
  input  logic          inv_vld_i,
  input  logic [LW-1:0] inv_line_i,
  output logic          own_req_o,
  output logic [LW-1:0] own_line_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             busy_q, req_pf_q, pf_live_q;
  logic [LW-1:0]    req_line_q, pf_line_q;
  logic [CNT_W-1:0] lost_q;
  logic             pf_en, need_dem, need_pf, issue, pf_used, pf_lost;

  assign pf_en    = (lost_q < CNT_W'(PF_OFF));
  assign need_dem = head_vld_i && !head_own_i;
  assign need_pf  = pf_en && nxt_vld_i && !nxt_own_i && (nxt_line_i != head_line_i);
  assign issue    = !busy_q && (need_dem || need_pf);

  // commit in the same cycle as a snoop counts as a use
  assign pf_used  = commit_i && pf_live_q && (head_line_i == pf_line_q);
  assign pf_lost  = inv_vld_i && pf_live_q && (inv_line_i == pf_line_q) && !pf_used;

  assign own_req_o  = busy_q;
  assign own_line_o = req_line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      req_pf_q   <= 1'b0;
      req_line_q <= '0;
    end else if (issue) begin
      busy_q     <= 1'b1;
      req_pf_q   <= !need_dem;
      req_line_q <= need_dem ? head_line_i : nxt_line_i;
    end else if (own_gnt_i) begin
      busy_q     <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pf_live_q <= 1'b0;
      pf_line_q <= '0;
    end else if (own_gnt_i && req_pf_q) begin
      pf_live_q <= 1'b1;
      pf_line_q <= req_line_q;
    end else if (pf_used || pf_lost) begin
      pf_live_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lost_q <= '0;
    else if (pf_lost && (lost_q != CNT_MAX)) lost_q <= lost_q + CNT_W'(1);
  end

  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_req_o && !own_gnt_i |=> own_req_o && $stable(own_line_o));

  // R5
  gnt_only_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_gnt_i |-> own_req_o);

  // R5
  no_b2b_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_gnt_i |=> !own_req_o);

  // R8
  lost_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> lost_q >= $past(lost_q));

  // R8
  pf_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(own_req_o) && req_pf_q |-> $past(lost_q) < CNT_W'(PF_OFF));

endmodule

// File: rtl/sb_commit.sv
module sb_commit
  import sb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int OFF_W = 6,
  localparam int LW   = AW - OFF_W,
  localparam int MW   = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          st_vld_i,
  input  logic [AW-1:0] st_addr_i,
  input  logic [DW-1:0] st_data_i,
  input  logic [MW-1:0] st_mask_i,
  output logic          st_full_o,
  output logic [AW-1:0] l1_addr_o,
  input  logic [1:0]    l1_state_i,
  input  logic          l1_rdy_i,
  output logic          l1_wr_o,
  output logic [DW-1:0] l1_wr_data_o,
  output logic [MW-1:0] l1_wr_mask_o,
  output logic [1:0]    l1_wr_state_o,
  output logic [LW-1:0] pf_line_o,
  input  logic [1:0]    pf_state_i,
  output logic          own_req_o,
  output logic [LW-1:0] own_line_o,
  input  logic          own_gnt_i,
  input  logic          inv_vld_i,
  input  logic [LW-1:0] inv_line_i
);

  logic          push_acc, head_vld, nxt_vld, head_own, commit;
  logic [LW-1:0] head_line;

  sb_fifo #(
    .DEPTH (DEPTH),
    .AW    (AW),
    .DW    (DW),
    .LW    (LW)
  ) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (st_vld_i),
    .push_addr_i (st_addr_i),
    .push_data_i (st_data_i),
    .push_mask_i (st_mask_i),
    .pop_i       (commit),
    .push_acc_o  (push_acc),
    .full_o      (st_full_o),
    .head_vld_o  (head_vld),
    .head_addr_o (l1_addr_o),
    .head_data_o (l1_wr_data_o),
    .head_mask_o (l1_wr_mask_o),
    .nxt_vld_o   (nxt_vld),
    .nxt_line_o  (pf_line_o)
  );

  assign head_line     = l1_addr_o[AW-1:OFF_W];
  assign head_own      = has_wr_perm(l1_state_i);
  assign commit        = head_vld && head_own && l1_rdy_i;
  assign l1_wr_o       = commit;
  assign l1_wr_state_o = ST_M;

  sb_own_ctrl #(
    .LW (LW)
  ) u_own (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .head_vld_i  (head_vld),
    .head_line_i (head_line),
    .head_own_i  (head_own),
    .nxt_vld_i   (nxt_vld),
    .nxt_line_i  (pf_line_o),
    .nxt_own_i   (has_wr_perm(pf_state_i)),
    .commit_i    (commit),
    .own_gnt_i   (own_gnt_i),
    .inv_vld_i   (inv_vld_i),
    .inv_line_i  (inv_line_i),
    .own_req_o   (own_req_o),
    .own_line_o  (own_line_o)
  );

  // R6
  inv_no_touch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_vld_i && !push_acc && !l1_wr_o |=>
      $stable(l1_addr_o) && $stable(l1_wr_data_o) && $stable(st_full_o));

endmodule

// File: tb/sb_commit_tb_top.sv
module sb_commit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int LW = 26;
  localparam int MW = 8;

  logic clk, rst_n;
  logic st_vld, st_full, l1_rdy, l1_wr, own_req, gnt, inv_v;
  logic [AW-1:0] st_addr, l1_addr;
  logic [DW-1:0] st_data, l1_wr_data;
  logic [MW-1:0] st_mask, l1_wr_mask;
  logic [1:0]    l1_state, pf_state, l1_wr_state;
  logic [LW-1:0] pf_line, own_line, inv_line;

  sb_commit dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .st_vld_i(st_vld), .st_addr_i(st_addr), .st_data_i(st_data), .st_mask_i(st_mask),
    .st_full_o(st_full),
    .l1_addr_o(l1_addr), .l1_state_i(l1_state), .l1_rdy_i(l1_rdy), .l1_wr_o(l1_wr),
    .l1_wr_data_o(l1_wr_data), .l1_wr_mask_o(l1_wr_mask), .l1_wr_state_o(l1_wr_state),
    .pf_line_o(pf_line), .pf_state_i(pf_state),
    .own_req_o(own_req), .own_line_o(own_line), .own_gnt_i(gnt),
    .inv_vld_i(inv_v), .inv_line_i(inv_line)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // cache state model, 16 lines
  logic [1:0] st [16];
  logic       set_v;
  logic [3:0] set_i;
  logic [1:0] set_val;
  assign l1_state = st[l1_addr[9:6]];
  assign pf_state = st[pf_line[3:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) st[i] <= 2'd0;
    end else begin
      if (set_v) st[set_i] <= set_val;
      if (l1_wr) st[l1_addr[9:6]] <= l1_wr_state;
      if (gnt)   st[own_line[3:0]] <= 2'd2;
      if (inv_v) st[inv_line[3:0]] <= 2'd0;
    end
  end

  // grant agent: one reply per request
  bit gnt_hold;
  int gnt_lat, gnt_wt;
  always @(negedge clk) begin
    if (!rst_n) begin
      gnt <= 1'b0; gnt_wt <= 0;
    end else if (gnt) begin
      gnt <= 1'b0; gnt_wt <= 0;
    end else if (own_req && !gnt_hold) begin
      if (gnt_wt >= gnt_lat) gnt <= 1'b1;
      else gnt_wt <= gnt_wt + 1;
    end
  end

  // expected commit stream and monitor
  logic [AW-1:0] exp_addr [64];
  logic [DW-1:0] exp_data [64];
  logic [MW-1:0] exp_mask [64];
  int exp_wr, exp_rd, mon_chk, mon_bad, req_rises;
  bit req_d;
  int n_chk, n_bad, cyc;

  always @(posedge clk) begin
    if (rst_n) begin
      if (l1_wr) begin
        mon_chk++;
        if (exp_rd >= exp_wr) begin
          mon_bad++;
          $display("FAIL R2 extra commit act_addr=%h exp=none", l1_addr);
        end else begin
          if (l1_addr !== exp_addr[exp_rd] || l1_wr_data !== exp_data[exp_rd] ||
              l1_wr_mask !== exp_mask[exp_rd]) begin
            mon_bad++;
            $display("FAIL R2 commit act=%h/%h exp=%h/%h", l1_addr, l1_wr_data,
                     exp_addr[exp_rd], exp_data[exp_rd]);
          end
          exp_rd++;
        end
      end
      if (own_req && !req_d) req_rises++;
      req_d = own_req;
    end else begin
      req_d = 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      $display("FAIL watchdog act=%0d exp<=100000", cyc);
      $display("test done: total=%0d bad=%0d", n_chk + mon_chk + 1, n_bad + mon_bad + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  int seq;

  task automatic push_st(input int line, input bit record);
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    @(negedge clk);
    seq++;
    a = (AW'(line) << 6) | AW'(seq % 8);
    d = {32'(seq) * 32'h9E37_79B1, 32'(seq)};
    if (record && !st_full) begin
      exp_addr[exp_wr] = a; exp_data[exp_wr] = d; exp_mask[exp_wr] = 8'hFF ^ 8'(seq);
      exp_wr++;
    end
    st_vld = 1'b1; st_addr = a; st_data = d; st_mask = 8'hFF ^ 8'(seq);
    @(negedge clk);
    st_vld = 1'b0;
  endtask

  task automatic set_line(input int line, input logic [1:0] v);
    @(negedge clk);
    set_v = 1'b1; set_i = 4'(line); set_val = v;
    @(negedge clk);
    set_v = 1'b0;
  endtask

  task automatic send_inv(input int line);
    @(negedge clk);
    inv_v = 1'b1; inv_line = LW'(line);
    @(negedge clk);
    inv_v = 1'b0;
  endtask

  task automatic drain(input string rq);
    int t = 0;
    while (exp_rd != exp_wr && t < 300) begin
      @(negedge clk);
      t++;
    end
    chk(exp_rd == exp_wr, rq, exp_rd, exp_wr);
  endtask

  // prefetch/loss round; returns via checks
  task automatic pf_round(input int la, input int lb, input bit exp_pf, input string rq);
    int r0, r1;
    l1_rdy = 1'b0;
    set_line(la, 2'd3);
    set_line(lb, 2'd0);
    r0 = req_rises;
    push_st(la, 1'b1);
    push_st(lb, 1'b1);
    repeat (8) @(negedge clk);
    chk((req_rises - r0) == (exp_pf ? 1 : 0), rq, req_rises - r0, exp_pf ? 1 : 0);
    chk(st[lb] == (exp_pf ? 2'd2 : 2'd0), rq, st[lb], exp_pf ? 2 : 0);
    send_inv(lb);
    @(negedge clk);
    chk(st[lb] == 2'd0, "R6", st[lb], 0);
    r1 = req_rises;
    l1_rdy = 1'b1;
    drain("R9");
    // R9: the lost line is requested again on demand
    chk((req_rises - r1) == 1, "R9", req_rises - r1, 1);
  endtask

  initial begin
    int cnt0;
    st_vld = 0; st_addr = '0; st_data = '0; st_mask = '0;
    l1_rdy = 1'b1; inv_v = 0; inv_line = '0;
    set_v = 0; set_i = '0; set_val = '0;
    gnt_hold = 0; gnt_lat = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk(st_full == 1'b0, "R1 reset full", st_full, 0);
    chk(own_req == 1'b0, "R4 reset req", own_req, 0);
    chk(l1_wr == 1'b0, "R2 reset wr", l1_wr, 0);

    // R3/R4 sweep: start state x grant latency
    for (int s = 0; s < 4; s++) begin
      for (int lat = 0; lat < 3; lat++) begin
        int ln = s * 3 + lat;
        int r0;
        gnt_lat = lat;
        set_line(ln, 2'(s));
        r0 = req_rises;
        push_st(ln, 1'b1);
        drain("R2");
        chk((req_rises - r0) == (s < 2 ? 1 : 0), "R4", req_rises - r0, s < 2 ? 1 : 0);
        chk(st[ln] == 2'd3, "R3", st[ln], 3);
      end
    end

    // R1 capacity and drop, R5 single outstanding
    gnt_lat = 1;
    gnt_hold = 1;
    for (int i = 0; i < 8; i++) set_line(i, 2'd0);
    for (int i = 0; i < 8; i++) push_st(i, 1'b1);
    @(negedge clk);
    chk(st_full == 1'b1, "R1 full at 8", st_full, 1);
    push_st(9, 1'b0);
    chk(st_full == 1'b1, "R1 full after drop", st_full, 1);
    chk(own_req && own_line == LW'(0), "R5 one req head line", own_line, 0);
    cnt0 = exp_rd;
    gnt_hold = 0;
    drain("R1");
    repeat (4) @(negedge clk);
    chk((mon_chk - cnt0) >= 0 && exp_rd - cnt0 == 8, "R1 commits", exp_rd - cnt0, 8);
    chk(st_full == 1'b0, "R1 empty", st_full, 0);

    // R6 invalidations ignored by buffered stores
    gnt_hold = 1;
    for (int i = 8; i < 11; i++) set_line(i, 2'd0);
    for (int i = 8; i < 11; i++) push_st(i, 1'b1);
    for (int i = 8; i < 11; i++) send_inv(i);
    send_inv(8);
    chk(own_req && own_line == LW'(8), "R4 req held", own_line, 8);
    chk(exp_rd != exp_wr, "R6 nothing visible", exp_wr - exp_rd, 3);
    gnt_hold = 0;
    drain("R6");

    // R8 same-cycle commit and invalidation counts as use
    gnt_lat = 0;
    l1_rdy = 1'b0;
    set_line(11, 2'd3);
    set_line(12, 2'd0);
    cnt0 = req_rises;
    push_st(11, 1'b1);
    push_st(12, 1'b1);
    repeat (8) @(negedge clk);
    chk(req_rises - cnt0 == 1, "R7 prefetch", req_rises - cnt0, 1);
    chk(st[12] == 2'd2, "R7 prefetched E", st[12], 2);
    l1_rdy = 1'b1;
    @(negedge clk);
    inv_v = 1'b1; inv_line = LW'(12);
    @(negedge clk);
    inv_v = 1'b0;
    drain("R8 collision");
    chk(st[12] == 2'd0, "R8 inv applied", st[12], 0);

    // two losses allowed to prefetch, third must not
    pf_round(13, 14, 1'b1, "R8 round1");
    pf_round(3, 4, 1'b1, "R8 round2");
    pf_round(5, 6, 1'b0, "R8 round3");

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk + mon_chk, n_bad + mon_bad);
    $finish;
  end

endmodule